// File: doc/BRIEF.md
# Secure Vector Store and Lock Controller

This block keeps the reset and interrupt vector code of a processor in a small on-chip byte store, so that fetches from the lowest logical addresses never reach the external program memory bus. Any CPU fetch that falls inside the vector region is answered from the internal store. In the same cycle the block raises a request that tells the external bus interface to run a dummy read, so bus activity looks the same as for an ordinary fetch.

The same block is the loader's gatekeeper. It accepts loader commands that write and read vector bytes, grant program-memory reads and writes, set the security lock, release it, and start a program load. Starting a load first asks an external key source for a fresh key through a request/acknowledge handshake. While the lock is set, every loader access to vector or program data is refused. Releasing the lock wipes the vector store one byte per cycle, invalidates the key, and only then drops the lock. A power-on reset clears everything. A CPU warm reset keeps the lock, the key state and the vector contents.

Top module: `vector_vault`

## Requirements
- R1: The store holds 48 bytes at logical addresses 0x0000 to 0x002F. A loader vector write (ld_op 1) that is accepted while unlocked with a valid key stores ld_wdata. A vector read (ld_op 2) returns the byte on ld_rdata one cycle after acceptance. Either op with an address of 0x0030 or above raises ld_refused and leaves the store unchanged.
- R2: A CPU fetch with cpu_addr below 0x0030 drives vec_sel=1 and vec_data equal to the stored byte one cycle later. This includes the fetch of 0x0000 right after reset.
- R3: dummy_req is 1 in exactly the cycles where vec_sel is 1. A fetch at 0x0030 or above, or no fetch, gives vec_sel=0, dummy_req=0 and vec_data=0x00.
- R4: The set-lock op (ld_op 5) drives lock=1 one cycle after acceptance. Only a completed release sequence clears it.
- R5: While lock=1, vector writes are ignored (the store, as seen through CPU fetches, is unchanged) and raise ld_refused. Vector reads return 0x00 with ld_refused. Program writes and reads (ld_op 3 and 4) are refused without pgm_go. The load op (ld_op 7) is refused without key_req.
- R6: The release op (ld_op 6) makes ld_busy=1 from the next cycle and zeroes all 48 bytes. lock falls exactly 48 cycles after the accepting edge, in the same cycle as a one-cycle key_inval pulse. Commands offered while ld_busy=1 are not accepted (no ld_ack).
- R7: The load op, when unlocked, raises key_req and ld_busy in the next cycle and holds them until key_ack is sampled. Both fall one cycle after that. Vector writes and program writes are refused whenever no key has been delivered since power-on or since the last release.
- R8: Power-on reset (por_n=0) clears the lock, the key state and the store. A warm reset (warm_n=0) clears ld_busy, key_req and the fetch outputs, but keeps lock, the key state and the vector bytes.
- R9: Every accepted command other than ld_op 0 gives a one-cycle ld_ack pulse one cycle after acceptance. An accepted program write or read that is permitted gives a one-cycle pgm_go pulse in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| warm_n | input | 1 | CPU warm reset, active low |
| cpu_fetch | input | 1 | CPU fetch strobe |
| cpu_addr | input | 16 | Logical fetch address |
| vec_sel | output | 1 | Fetch served from the internal store |
| vec_data | output | 8 | Byte from the internal store |
| dummy_req | output | 1 | Ask the bus interface for a dummy read |
| ld_valid | input | 1 | Loader command strobe |
| ld_op | input | 3 | Loader opcode (0 none, 1 vec write, 2 vec read, 3 prog write, 4 prog read, 5 lock, 6 release, 7 load) |
| ld_addr | input | 16 | Loader address |
| ld_wdata | input | 8 | Loader write byte |
| ld_busy | output | 1 | Key wait or release sequence in progress |
| ld_ack | output | 1 | Command accepted pulse |
| ld_refused | output | 1 | Command refused pulse |
| ld_rdata | output | 8 | Vector read data |
| pgm_go | output | 1 | Program memory access permitted pulse |
| key_req | output | 1 | Fresh key request |
| key_ack | input | 1 | Key delivered |
| key_inval | output | 1 | Key invalidation pulse |
| lock | output | 1 | Security lock state |

## Verification
Every result is registered. Fetch outputs, ld_ack, ld_refused, ld_rdata, pgm_go and the lock rise appear one cycle after the edge that takes the stimulus, so the bench drives on a falling edge and samples on the next falling edge. key_req follows the same one-cycle rule, and its fall is due one cycle after key_ack is sampled. The lock fall and the key_inval pulse are due exactly 48 cycles after the accepting edge; the bench counts falling edges and checks the lock at every count up to that point, then the fall and the pulse at the 48th.

// File: rtl/vv_pkg.sv
package vv_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_VWR    = 3'd1,
        OP_VRD    = 3'd2,
        OP_PWR    = 3'd3,
        OP_PRD    = 3'd4,
        OP_LOCK   = 3'd5,
        OP_UNLOCK = 3'd6,
        OP_LOAD   = 3'd7
    } ld_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_KEYWAIT = 2'd1,
        ST_ERASE   = 2'd2
    } ctl_st_e;
endpackage

// File: rtl/vv_store.sv
module vv_store #(
    parameter int VEC_BYTES = 48,
    parameter int IDX_W     = $clog2(VEC_BYTES)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] idx_a,
    output logic [7:0]       rd_a,
    input  logic [IDX_W-1:0] idx_b,
    output logic [7:0]       rd_b
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(VEC_BYTES);

    logic [VEC_BYTES-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (wr_idx < LIMIT)) begin
            mem_d[wr_idx] = wr_data;
        end
        rd_a = (idx_a < LIMIT) ? mem_q[idx_a] : 8'h00;
        rd_b = (idx_b < LIMIT) ? mem_q[idx_b] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/vv_fetch.sv
module vv_fetch #(
    parameter int ADDR_W    = 16,
    parameter int VEC_BYTES = 48,
    parameter int IDX_W     = $clog2(VEC_BYTES)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    input  logic [7:0]        rd_data,
    output logic              sel,
    output logic [7:0]        data,
    output logic              dummy
);
    typedef struct packed {
        logic       sel;
        logic       dummy;
        logic [7:0] data;
    } fet_t;

    localparam fet_t FET_RST = '{sel: 1'b0, dummy: 1'b0, data: 8'h00};

    fet_t fet_d, fet_q;
    logic hit;

    always_comb begin
        idx         = addr[IDX_W-1:0];
        hit         = fetch && (addr < ADDR_W'(VEC_BYTES));
        fet_d.sel   = hit;
        fet_d.dummy = hit;
        fet_d.data  = hit ? rd_data : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!por_n || !warm_n) begin
            fet_q <= FET_RST;
        end else begin
            fet_q <= fet_d;
        end
    end

    assign sel   = fet_q.sel;
    assign dummy = fet_q.dummy;
    assign data  = fet_q.data;
endmodule

// File: rtl/vv_ctrl.sv
module vv_ctrl
    import vv_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int VEC_BYTES = 48,
    parameter int IDX_W     = $clog2(VEC_BYTES)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              key_ack,
    input  logic [7:0]        rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [7:0]        wr_data,
    output logic              busy,
    output logic              lock,
    output logic              key_req,
    output logic              key_inval,
    output logic              ack,
    output logic              refused,
    output logic [7:0]        rdata,
    output logic              pgm_go
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(VEC_BYTES - 1);

    typedef struct packed {
        ctl_st_e          st;
        logic [IDX_W-1:0] cnt;
        logic             lock;
        logic             key_ok;
        logic             key_req;
        logic             key_inval;
        logic             ack;
        logic             refused;
        logic [7:0]       rdata;
        logic             pgm_go;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, cnt: '0, lock: 1'b0, key_ok: 1'b0,
                                 key_req: 1'b0, key_inval: 1'b0, ack: 1'b0,
                                 refused: 1'b0, rdata: 8'h00, pgm_go: 1'b0};

    function automatic ctl_t warm_clear(input ctl_t s);
        ctl_t r;
        r        = CTL_RST;
        r.lock   = s.lock;
        r.key_ok = s.key_ok;
        return r;
    endfunction

    ctl_t   ctl_d, ctl_q;
    ld_op_e op;
    logic   in_range;
    logic   wr_int;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.key_inval = 1'b0;
        ctl_d.ack       = 1'b0;
        ctl_d.refused   = 1'b0;
        ctl_d.rdata     = 8'h00;
        ctl_d.pgm_go    = 1'b0;
        op              = ld_op_e'(cmd_op);
        in_range        = cmd_addr < ADDR_W'(VEC_BYTES);
        wr_int          = 1'b0;
        wr_idx          = cmd_addr[IDX_W-1:0];
        wr_data         = cmd_wdata;
        rd_idx          = cmd_addr[IDX_W-1:0];
        case (ctl_q.st)
            ST_IDLE: begin
                if (cmd_valid && (op != OP_NOP)) begin
                    ctl_d.ack = 1'b1;
                    case (op)
                        OP_VWR: begin
                            if (ctl_q.lock || !ctl_q.key_ok || !in_range) ctl_d.refused = 1'b1;
                            else wr_int = 1'b1;
                        end
                        OP_VRD: begin
                            if (ctl_q.lock || !in_range) ctl_d.refused = 1'b1;
                            else ctl_d.rdata = rd_data;
                        end
                        OP_PWR: begin
                            if (ctl_q.lock || !ctl_q.key_ok) ctl_d.refused = 1'b1;
                            else ctl_d.pgm_go = 1'b1;
                        end
                        OP_PRD: begin
                            if (ctl_q.lock) ctl_d.refused = 1'b1;
                            else ctl_d.pgm_go = 1'b1;
                        end
                        OP_LOCK: ctl_d.lock = 1'b1;
                        OP_UNLOCK: begin
                            ctl_d.st  = ST_ERASE;
                            ctl_d.cnt = '0;
                        end
                        OP_LOAD: begin
                            if (ctl_q.lock) begin
                                ctl_d.refused = 1'b1;
                            end else begin
                                ctl_d.st      = ST_KEYWAIT;
                                ctl_d.key_req = 1'b1;
                                ctl_d.key_ok  = 1'b0;
                            end
                        end
                        default: ctl_d.ack = 1'b0;
                    endcase
                end
            end
            ST_KEYWAIT: begin
                if (key_ack) begin
                    ctl_d.key_req = 1'b0;
                    ctl_d.key_ok  = 1'b1;
                    ctl_d.st      = ST_IDLE;
                end
            end
            ST_ERASE: begin
                wr_int  = 1'b1;
                wr_idx  = ctl_q.cnt;
                wr_data = 8'h00;
                if (ctl_q.cnt == LAST) begin
                    ctl_d.st        = ST_IDLE;
                    ctl_d.lock      = 1'b0;
                    ctl_d.key_ok    = 1'b0;
                    ctl_d.key_inval = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        wr_en = wr_int && warm_n;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            ctl_q <= CTL_RST;
        end else if (!warm_n) begin
            ctl_q <= warm_clear(ctl_q);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy      = (ctl_q.st != ST_IDLE);
    assign lock      = ctl_q.lock;
    assign key_req   = ctl_q.key_req;
    assign key_inval = ctl_q.key_inval;
    assign ack       = ctl_q.ack;
    assign refused   = ctl_q.refused;
    assign rdata     = ctl_q.rdata;
    assign pgm_go    = ctl_q.pgm_go;
endmodule

// File: rtl/vector_vault.sv
module vector_vault #(
    parameter int ADDR_W    = 16,
    parameter int VEC_BYTES = 48
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_n,
    input  logic              cpu_fetch,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              vec_sel,
    output logic [7:0]        vec_data,
    output logic              dummy_req,
    input  logic              ld_valid,
    input  logic [2:0]        ld_op,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_wdata,
    output logic              ld_busy,
    output logic              ld_ack,
    output logic              ld_refused,
    output logic [7:0]        ld_rdata,
    output logic              pgm_go,
    output logic              key_req,
    input  logic              key_ack,
    output logic              key_inval,
    output logic              lock
);
    localparam int IDX_W = $clog2(VEC_BYTES);

    logic [IDX_W-1:0] fet_idx, ld_idx, wr_idx;
    logic [7:0]       fet_byte, ld_byte, wr_data;
    logic             wr_en;

    vv_store #(.VEC_BYTES(VEC_BYTES), .IDX_W(IDX_W)) i_store (
        .clk(clk), .por_n(por_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .idx_a(fet_idx), .rd_a(fet_byte),
        .idx_b(ld_idx), .rd_b(ld_byte)
    );

    vv_fetch #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES), .IDX_W(IDX_W)) i_fetch (
        .clk(clk), .por_n(por_n), .warm_n(warm_n),
        .fetch(cpu_fetch), .addr(cpu_addr), .idx(fet_idx), .rd_data(fet_byte),
        .sel(vec_sel), .data(vec_data), .dummy(dummy_req)
    );

    vv_ctrl #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES), .IDX_W(IDX_W)) i_ctrl (
        .clk(clk), .por_n(por_n), .warm_n(warm_n),
        .cmd_valid(ld_valid), .cmd_op(ld_op), .cmd_addr(ld_addr), .cmd_wdata(ld_wdata),
        .key_ack(key_ack), .rd_data(ld_byte), .rd_idx(ld_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .busy(ld_busy), .lock(lock), .key_req(key_req), .key_inval(key_inval),
        .ack(ld_ack), .refused(ld_refused), .rdata(ld_rdata), .pgm_go(pgm_go)
    );
endmodule

// File: rtl/vv_checker.sv
module vv_checker
    import vv_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int VEC_BYTES = 48
) (
    input logic              clk,
    input logic              por_n,
    input logic              warm_n,
    input logic              cpu_fetch,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              vec_sel,
    input logic              dummy_req,
    input logic              ld_valid,
    input logic [2:0]        ld_op,
    input logic              ld_busy,
    input logic              ld_ack,
    input logic [7:0]        ld_rdata,
    input logic              pgm_go,
    input logic              key_req,
    input logic              key_inval,
    input logic              lock
);
    a_r2_region_served: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
        (cpu_fetch && (cpu_addr < ADDR_W'(VEC_BYTES))) |=> (vec_sel && dummy_req));

    a_r3_no_dummy_outside: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
        (!cpu_fetch || (cpu_addr >= ADDR_W'(VEC_BYTES))) |=> (!dummy_req && !vec_sel));

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (lock && !ld_busy && !(ld_valid && warm_n && (ld_op == OP_UNLOCK))) |=> lock);

    a_r5_locked_quiet: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
        (lock && ld_valid && !ld_busy) |=> (!pgm_go && (ld_rdata == 8'h00) && !key_req));

    a_r6_inval_at_release: assert property (@(posedge clk) disable iff (!por_n)
        $fell(lock) |-> key_inval);

    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
        ld_busy |=> !ld_ack);

    a_r7_req_means_busy: assert property (@(posedge clk) disable iff (!por_n)
        key_req |-> ld_busy);

    a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
        (ld_valid && !ld_busy && (ld_op != OP_NOP)) |=> ld_ack);
endmodule

bind vector_vault vv_checker #(.ADDR_W(ADDR_W), .VEC_BYTES(VEC_BYTES)) i_vv_checker (.*);

// File: tb/test_vector_vault.sv
module test_vector_vault;
    logic        clk = 1'b0;
    logic        por_n = 1'b0, warm_n = 1'b1;
    logic        cpu_fetch = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        vec_sel, dummy_req;
    logic [7:0]  vec_data;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_op = '0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  ld_wdata = '0;
    logic        ld_busy, ld_ack, ld_refused, pgm_go, key_req, key_inval, lock;
    logic [7:0]  ld_rdata;
    logic        key_ack = 1'b0;
    int          checks = 0, errors = 0;

    always #4 clk = ~clk;

    vector_vault i_vector_vault (
        .clk(clk), .por_n(por_n), .warm_n(warm_n),
        .cpu_fetch(cpu_fetch), .cpu_addr(cpu_addr),
        .vec_sel(vec_sel), .vec_data(vec_data), .dummy_req(dummy_req),
        .ld_valid(ld_valid), .ld_op(ld_op), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
        .ld_busy(ld_busy), .ld_ack(ld_ack), .ld_refused(ld_refused), .ld_rdata(ld_rdata),
        .pgm_go(pgm_go), .key_req(key_req), .key_ack(key_ack),
        .key_inval(key_inval), .lock(lock)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic        exp_ref;
        logic [7:0]  exp_rdata;
        logic        exp_go;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{3'd1, 16'h0000, 8'hA5, 1'b0, 8'h00, 1'b0},
        '{3'd1, 16'h002F, 8'h3C, 1'b0, 8'h00, 1'b0},
        '{3'd1, 16'h0030, 8'h77, 1'b1, 8'h00, 1'b0},
        '{3'd2, 16'h0000, 8'h00, 1'b0, 8'hA5, 1'b0},
        '{3'd2, 16'h002F, 8'h00, 1'b0, 8'h3C, 1'b0},
        '{3'd2, 16'h0030, 8'h00, 1'b1, 8'h00, 1'b0},
        '{3'd3, 16'h1234, 8'h99, 1'b0, 8'h00, 1'b1},
        '{3'd4, 16'h0100, 8'h00, 1'b0, 8'h00, 1'b1},
        '{3'd1, 16'h0010, 8'h5A, 1'b0, 8'h00, 1'b0},
        '{3'd2, 16'h0010, 8'h00, 1'b0, 8'h5A, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [15:0] a, input logic [7:0] w);
        @(negedge clk);
        ld_valid = 1'b1; ld_op = op; ld_addr = a; ld_wdata = w;
        @(negedge clk);
        ld_valid = 1'b0; ld_op = 3'd0;
    endtask

    task automatic fetch(input logic [15:0] a);
        @(negedge clk);
        cpu_fetch = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_fetch = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        // R8 power-on state
        chk("R8 lock after POR", {15'd0, lock}, 16'd0);
        chk("R8 busy after POR", {15'd0, ld_busy}, 16'd0);
        chk("R8 key_req after POR", {15'd0, key_req}, 16'd0);
        chk("R3 dummy idle", {15'd0, dummy_req}, 16'd0);

        // R2 reset vector fetch served internally
        fetch(16'h0000);
        chk("R2 sel at 0x0000", {15'd0, vec_sel}, 16'd1);
        chk("R2 data at 0x0000", {8'd0, vec_data}, 16'h0000);
        chk("R3 dummy at 0x0000", {15'd0, dummy_req}, 16'd1);

        // R7 no key yet: writes refused
        cmd(3'd1, 16'h0000, 8'hEE);
        chk("R7 vec write without key", {15'd0, ld_refused}, 16'd1);
        cmd(3'd3, 16'h0200, 8'h01);
        chk("R7 prog write without key", {14'd0, ld_refused, pgm_go}, 16'b10);

        // R7 key handshake
        cmd(3'd7, 16'h0000, 8'h00);
        chk("R9 ack on load", {15'd0, ld_ack}, 16'd1);
        chk("R7 key_req raised", {14'd0, key_req, ld_busy}, 16'b11);
        repeat (3) @(negedge clk);
        chk("R7 key_req held", {14'd0, key_req, ld_busy}, 16'b11);
        key_ack = 1'b1;
        @(negedge clk);
        key_ack = 1'b0;
        chk("R7 key_req dropped", {14'd0, key_req, ld_busy}, 16'b00);

        // R1 R9 table walk
        for (int i = 0; i < NVEC; i++) begin
            cmd(TBL[i].op, TBL[i].addr, TBL[i].wdata);
            chk($sformatf("R9 ack row %0d", i), {15'd0, ld_ack}, 16'd1);
            chk($sformatf("R1 refused row %0d", i), {15'd0, ld_refused}, {15'd0, TBL[i].exp_ref});
            chk($sformatf("R1 rdata row %0d", i), {8'd0, ld_rdata}, {8'd0, TBL[i].exp_rdata});
            chk($sformatf("R9 pgm_go row %0d", i), {15'd0, pgm_go}, {15'd0, TBL[i].exp_go});
        end

        // R2 R3 fetch patterns
        fetch(16'h0000);
        chk("R2 fetch 0x0000", {7'd0, vec_sel, vec_data}, {7'd0, 1'b1, 8'hA5});
        fetch(16'h002F);
        chk("R2 fetch 0x002F", {7'd0, vec_sel, vec_data}, {7'd0, 1'b1, 8'h3C});
        chk("R3 dummy 0x002F", {15'd0, dummy_req}, 16'd1);
        fetch(16'h0030);
        chk("R3 fetch 0x0030", {6'd0, vec_sel, dummy_req, vec_data}, 16'h0000);
        @(negedge clk);
        chk("R3 no fetch", {15'd0, dummy_req}, 16'd0);

        // R4 lock
        cmd(3'd5, 16'h0000, 8'h00);
        chk("R4 lock set", {15'd0, lock}, 16'd1);
        // R5 refusals while locked
        cmd(3'd1, 16'h0000, 8'h11);
        chk("R5 vec write refused", {15'd0, ld_refused}, 16'd1);
        fetch(16'h0000);
        chk("R5 store unchanged", {8'd0, vec_data}, 16'h00A5);
        cmd(3'd2, 16'h0010, 8'h00);
        chk("R5 vec read zero", {7'd0, ld_refused, ld_rdata}, {7'd0, 1'b1, 8'h00});
        cmd(3'd3, 16'h0040, 8'h22);
        chk("R5 prog write refused", {14'd0, ld_refused, pgm_go}, 16'b10);
        cmd(3'd4, 16'h0040, 8'h00);
        chk("R5 prog read refused", {14'd0, ld_refused, pgm_go}, 16'b10);
        cmd(3'd7, 16'h0000, 8'h00);
        chk("R5 load refused", {14'd0, ld_refused, key_req}, 16'b10);
        chk("R4 lock held", {15'd0, lock}, 16'd1);

        // R8 warm reset keeps lock and store
        @(negedge clk); warm_n = 1'b0;
        @(negedge clk); @(negedge clk); warm_n = 1'b1;
        chk("R8 lock kept over warm reset", {15'd0, lock}, 16'd1);
        fetch(16'h0010);
        chk("R8 store kept over warm reset", {8'd0, vec_data}, 16'h005A);

        // R6 release sequence
        cmd(3'd6, 16'h0000, 8'h00);
        chk("R6 busy after release", {14'd0, ld_busy, lock}, 16'b11);
        for (int k = 1; k < 48; k++) begin
            @(negedge clk);
            if (k == 11) begin
                chk("R6 no ack while busy", {15'd0, ld_ack}, 16'd0);
                ld_valid = 1'b0; ld_op = 3'd0;
            end
            chk($sformatf("R6 lock held k=%0d", k), {15'd0, lock}, 16'd1);
            if (k == 10) begin
                ld_valid = 1'b1; ld_op = 3'd2; ld_addr = 16'h0000;
            end
        end
        @(negedge clk);
        chk("R6 lock released at 48", {15'd0, lock}, 16'd0);
        chk("R6 key_inval pulse", {15'd0, key_inval}, 16'd1);
        chk("R6 busy cleared", {15'd0, ld_busy}, 16'd0);
        fetch(16'h0000);
        chk("R6 byte 0 erased", {8'd0, vec_data}, 16'h0000);
        fetch(16'h002F);
        chk("R6 byte 47 erased", {8'd0, vec_data}, 16'h0000);
        cmd(3'd1, 16'h0001, 8'h33);
        chk("R7 key invalid after release", {15'd0, ld_refused}, 16'd1);

        // R8 POR clears lock
        cmd(3'd5, 16'h0000, 8'h00);
        chk("R4 relock", {15'd0, lock}, 16'd1);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        chk("R8 POR clears lock", {15'd0, lock}, 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule